// File: doc/BRIEF.md
# Carry-Save Multi-Operand Accumulator

This block sums a stream of operands. Each bit position has a full adder, so the array as a whole is a 3-to-2 compressor. The running total is not kept as one binary number. It is held as two vectors: a sum vector and a carry vector. On each accepted cycle, three values enter the array:

- the stored sum vector,
- the stored carry vector, moved up one bit position,
- the new operand.

No carry has to travel the full width of the word before the next operand can be taken, so one operand can be accepted on every clock.

The operand marked as the final one moves the block into a resolve phase. In this phase the same array keeps running with a zero in place of the operand until no carry is left pending. The sum vector then holds the plain binary total. The block raises a one-cycle completion pulse and keeps the total on its result output until the next start. All arithmetic wraps modulo 2^WIDTH.

Top module: `csa_accum`

## Requirements
- R1: After the final operand, `result_o` equals the modulo-2^WIDTH sum of every operand accepted since the last start when `done_o` is high.
- R2: A high `start_i` clears the stored sum and carry vectors to zero and opens a new stream. Starting takes priority: an operand presented in the same cycle as `start_i` is dropped.
- R3: While a stream is open, a cycle with `op_valid_i` low leaves the stored vectors unchanged and does not alter the final total.
- R4: The carry produced by the most significant bit position is discarded, so totals wrap modulo 2^WIDTH.
- R5: Once the operand flagged with `op_last_i` has been accepted, further operands are ignored until the next start. This holds whether or not those operands are flagged as last.
- R6: `done_o` is high for exactly one cycle per completed stream, and only once the pending carry vector is all zeros.
- R7: After the `done_o` pulse, `result_o` holds the total unchanged until the next start.
- R8: The resolve phase runs at most WIDTH+1 iterations (33 at the default width) before `done_o` rises.
- R9: After reset, `done_o` is low and `result_o` is zero. Operands presented before the first start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Clear the accumulator and open a new operand stream |
| op_valid_i | input | 1 | `op_data_i` carries an operand this cycle |
| op_last_i | input | 1 | Marks the valid operand as the final one of the stream |
| op_data_i | input | WIDTH | Operand value |
| result_o | output | WIDTH | Sum vector; the binary total once `done_o` has pulsed |
| done_o | output | 1 | One-cycle pulse when the total is resolved |

## Verification
The bench builds the block with its defaults: WIDTH of 32 and a two-stage reset synchronizer. At this width the bench can reach the worst-case resolve chain. An all-ones operand followed by a one leaves a single carry that climbs through 31 positions before it is dropped at the top. At the same width, pairs of values that have only the top bit set exercise the wrap at bit 31. The streams also cover idle gaps, operands sent during the resolve and hold phases, and a restart in the middle of a stream with an operand in the same cycle as `start_i`.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Accumulator phases: waiting for a start, taking operands,
  // draining pending carries, and holding the resolved total.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_RES  = 2'd2,
    ST_HOLD = 2'd3
  } acc_state_t;

endpackage

// File: rtl/csa_rst_sync.sv
module csa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  // Assertion is immediate; release walks through STAGES flops.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[LAST];

endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] s_o,
  output logic [WIDTH-2:0] cy_o
);

  // One full adder per bit. The top position produces no carry,
  // which is where the modulo wrap happens.
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign s_o[g] = a_i[g] ^ b_i[g] ^ c_i[g];
    if (g < WIDTH - 1) begin : g_cy
      assign cy_o[g] = (a_i[g] & b_i[g]) | (a_i[g] & c_i[g]) | (b_i[g] & c_i[g]);
    end
  end

endmodule

// File: rtl/csa_store.sv
module csa_store #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic [WIDTH-2:0] cy_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-2:0] carry_o
);

  logic [WIDTH-1:0] sum_q,   sum_d;
  logic [WIDTH-2:0] carry_q, carry_d;

  always_comb begin
    sum_d   = sum_q;
    carry_d = carry_q;
    if (clr_i) begin
      sum_d   = '0;
      carry_d = '0;
    end else if (en_i) begin
      sum_d   = s_i;
      carry_d = cy_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  assign sum_o   = sum_q;
  assign carry_o = carry_q;

endmodule

// File: rtl/csa_ctrl.sv
module csa_ctrl
  import csa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       valid_i,
  input  logic       last_i,
  input  logic       carry_zero_i,
  output acc_state_t state_o,
  output logic       clr_o,
  output logic       en_o,
  output logic       done_o
);

  acc_state_t state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    en_o    = 1'b0;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = ST_ACC;
      clr_o   = 1'b1;
    end else begin
      unique case (state_q)
        ST_ACC: begin
          if (valid_i) begin
            en_o = 1'b1;
            if (last_i) state_d = ST_RES;
          end
        end
        ST_RES: begin
          if (carry_zero_i) begin
            state_d = ST_HOLD;
            done_d  = 1'b1;
          end else begin
            en_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

endmodule

// File: rtl/csa_accum.sv
module csa_accum
  import csa_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_valid_i,
  input  logic             op_last_i,
  input  logic [WIDTH-1:0] op_data_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);

  localparam int CW = WIDTH - 1;

  logic             rst_q_n;
  acc_state_t       state;
  logic             clr, en, take_op, carry_zero;
  logic [WIDTH-1:0] sum_q, carry_in, third, row_s;
  logic [CW-1:0]    carry_q, row_cy;

  csa_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  // Stored carry i belongs to bit i+1; bit 0 gets zero.
  assign carry_in   = {carry_q, 1'b0};
  assign take_op    = (state == ST_ACC) && op_valid_i && !start_i;
  assign third      = take_op ? op_data_i : '0;
  assign carry_zero = ~|carry_q;

  csa_row #(.WIDTH(WIDTH)) i_row (
    .a_i  (sum_q),
    .b_i  (carry_in),
    .c_i  (third),
    .s_o  (row_s),
    .cy_o (row_cy)
  );

  csa_store #(.WIDTH(WIDTH)) i_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr_i   (clr),
    .en_i    (en),
    .s_i     (row_s),
    .cy_i    (row_cy),
    .sum_o   (sum_q),
    .carry_o (carry_q)
  );

  csa_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .start_i      (start_i),
    .valid_i      (op_valid_i),
    .last_i       (op_last_i),
    .carry_zero_i (carry_zero),
    .state_o      (state),
    .clr_o        (clr),
    .en_o         (en),
    .done_o       (done_o)
  );

  assign result_o = sum_q;

endmodule

// File: rtl/csa_accum_chk.sv
module csa_accum_chk
  import csa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             op_valid_i,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o,
  input logic [WIDTH-1:0] sum_q,
  input logic [WIDTH-2:0] carry_q,
  input acc_state_t       state
);

  localparam int BOUND = WIDTH + 1;
  localparam int CNT_W = $clog2(BOUND + 2) + 1;

  logic [CNT_W-1:0] res_cnt;

  // Counts the cycles spent in the resolve phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_cnt <= '0;
    end else if (state == ST_RES && !start_i) begin
      res_cnt <= res_cnt + 1'b1;
    end else begin
      res_cnt <= '0;
    end
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sum_q == '0) && (carry_q == '0) && (state == ST_ACC));

  a_r3_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC && !start_i && !op_valid_i) |=> $stable(sum_q) && $stable(carry_q));

  a_r5_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RES || state == ST_HOLD) && !start_i) |=> (state != ST_ACC));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (carry_q == '0));

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !start_i) |=> $stable(result_o));

  a_r8_resolve_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RES) |-> (res_cnt <= CNT_W'(BOUND)));

endmodule

bind csa_accum csa_accum_chk #(.WIDTH(WIDTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .start_i    (start_i),
  .op_valid_i (op_valid_i),
  .done_o     (done_o),
  .result_o   (result_o),
  .sum_q      (sum_q),
  .carry_q    (carry_q),
  .state      (state)
);

// File: tb/test_csa_accum.sv
module test_csa_accum;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, op_valid_i, op_last_i;
  logic [31:0] op_data_i;
  logic [31:0] result_o;
  logic        done_o;

  always #10 clk = ~clk;

  csa_accum i_csa_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_valid_i (op_valid_i),
    .op_last_i  (op_last_i),
    .op_data_i  (op_data_i),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  int          checks = 0;
  int          errors = 0;
  int          done_count = 0;
  int          cnt = 0;
  bit          armed = 1'b0;
  bit          real_last = 1'b0;
  bit          prev_done = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] stim[16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops expected totals when the completion pulse appears.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        armed = 1'b0;
        prev_done = 1'b0;
      end else begin
        if (armed) cnt++;
        if (!armed && real_last && op_valid_i && op_last_i && !start_i) begin
          armed = 1'b1;
          cnt = 0;
        end
        if (done_o) begin
          if (prev_done) begin
            chk(1'b0, "R6 done longer than one cycle", 32'd1, 32'd0);
          end else if (exp_q.size() == 0) begin
            chk(1'b0, "R6 done without a pending stream", 32'd1, 32'd0);
          end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(result_o == e, "R1 total", result_o, e);
            chk(armed && (cnt - 2) <= 33, "R8 resolve iterations", 32'(cnt - 2), 32'd33);
            armed = 1'b0;
            done_count++;
          end
        end
        prev_done = done_o;
      end
    end
  end

  task automatic wait_done(input int snap);
    while (done_count == snap) @(negedge clk);
  endtask

  task automatic run_stream(input int n, input bit gap);
    logic [31:0] e;
    int          snap;
    e = '0;
    for (int i = 0; i < n; i++) e = e + stim[i];
    exp_q.push_back(e);
    snap = done_count;
    @(posedge clk); #1;
    start_i = 1'b1; op_valid_i = 1'b0; op_last_i = 1'b0;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    chk(result_o == 32'd0, "R2 start clears", result_o, 32'd0);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      op_valid_i = 1'b1;
      op_data_i  = stim[i];
      op_last_i  = (i == n - 1);
      real_last  = (i == n - 1);
      if (gap && i != n - 1) begin
        @(posedge clk); #1;
        op_valid_i = 1'b0;       // R3 idle gap with a non-zero data bus
        op_data_i  = 32'hFFFF_FFFF;
      end
    end
    // R5: operands offered after the final one must be ignored.
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      real_last  = 1'b0;
      op_valid_i = 1'b1;
      op_last_i  = 1'b1;
      op_data_i  = 32'h0BAD_0000 + 32'(k);
    end
    @(posedge clk); #1;
    op_valid_i = 1'b0; op_last_i = 1'b0;
    wait_done(snap);
    repeat (4) @(negedge clk);
    chk(result_o == e, "R7 result held", result_o, e);
    chk(done_o == 1'b0, "R6 done low after pulse", 32'(done_o), 32'd0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0; start_i = 1'b0; op_valid_i = 1'b0; op_last_i = 1'b0; op_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0, "R9 done low after reset", 32'(done_o), 32'd0);
    chk(result_o == 32'd0, "R9 result zero after reset", result_o, 32'd0);

    // R9: operands before any start are ignored.
    @(posedge clk); #1;
    op_valid_i = 1'b1; op_last_i = 1'b1; op_data_i = 32'h0000_1234;
    repeat (3) @(posedge clk);
    #1 op_valid_i = 1'b0; op_last_i = 1'b0;
    @(negedge clk);
    chk(result_o == 32'd0, "R9 idle ignores operands", result_o, 32'd0);
    chk(done_o == 1'b0, "R9 idle no done", 32'(done_o), 32'd0);

    // R1: short stream without gaps.
    stim[0] = 32'd3; stim[1] = 32'd4; stim[2] = 32'd5;
    run_stream(3, 1'b0);

    // R4 and R8: longest carry chain, wraps to zero.
    stim[0] = 32'hFFFF_FFFF; stim[1] = 32'd1;
    run_stream(2, 1'b0);

    // R4: top-bit carries dropped, with R3 gaps.
    stim[0] = 32'h8000_0000; stim[1] = 32'h8000_0000; stim[2] = 32'd7;
    run_stream(3, 1'b1);

    // R1 and R3: mixed pattern with gaps.
    for (int i = 0; i < 8; i++) stim[i] = (32'h9E37_79B9 * 32'(i + 1)) ^ (32'(i) << 7);
    run_stream(8, 1'b1);

    // R1: single operand.
    stim[0] = 32'hDEAD_BEEF;
    run_stream(1, 1'b0);

    // R4: sixteen all-ones operands.
    for (int i = 0; i < 16; i++) stim[i] = 32'hFFFF_FFFF;
    run_stream(16, 1'b0);

    // R2: restart mid-stream; the operand beside start is dropped.
    exp_q.push_back(32'd9);
    snap = done_count;
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0; op_valid_i = 1'b1; op_data_i = 32'd5;
    @(posedge clk); #1 op_data_i = 32'd7;
    @(posedge clk); #1 start_i = 1'b1; op_data_i = 32'd100;
    @(posedge clk); #1 start_i = 1'b0; op_data_i = 32'd9; op_last_i = 1'b1; real_last = 1'b1;
    @(posedge clk); #1 op_valid_i = 1'b0; op_last_i = 1'b0; real_last = 1'b0;
    wait_done(snap);
    repeat (3) @(negedge clk);
    chk(result_o == 32'd9, "R2 restart total", result_o, 32'd9);
    chk(exp_q.size() == 0, "R6 every stream completed", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule